// File: doc/BRIEF.md
# ADC Two-Point Calibration Corrector

The corrector turns raw 12-bit converter codes into calibrated readings in millivolts for up to sixteen channels. For each channel a setup port stores a pair of ideal codes, the two voltages those codes should read as, the two measured trim deviations, and a flag that marks the channel as uncalibrated. A calibrate command then walks every channel once and derives three coefficients per channel: a gain-error term, a gain, and an offset.

After calibration, a conversion request carries a channel number and a raw code. On a calibrated channel the code is first corrected for offset and gain error by a signed division. On an uncalibrated channel the raw code is used directly. The intermediate result is then clamped at zero, with a separate flag raised when it was well below zero. Finally it is scaled by the channel gain. All arithmetic is signed 32-bit, and every division truncates toward zero. One shared restoring divider produces one quotient bit per cycle, so calibration and conversion both take many cycles, and `busy` is high for that whole time.

Top module: `adc_cal_corrector`

## Requirements
- R1: After reset `busy`, `rsp_valid`, `rsp_data` and `rsp_mismatch` are all 0, and every stored coefficient and setup value is 0.
- R2: A `cal_start` pulse in an idle cycle raises `busy` from the next cycle until every channel c has k = 1000 + (1000·(d2−d1))/(x2−x1), gain = ((v2−v1)·1000)/(x2−x1) and offset = d1·1000 − (k−1000)·x1. These are computed from the setup values that were in place when calibration started. `busy` falls when the last channel is done.
- R3: On a channel whose uncalibrated flag is 0, a request with code r returns t = (r·1000 − offset)/k, clamped at 0, multiplied by gain and divided by 1000.
- R4: On a channel whose uncalibrated flag is 1, the intermediate value is r itself. The response is (r·gain)/1000 and `rsp_mismatch` is 0.
- R5: A negative intermediate value is replaced by 0, so the response is 0.
- R6: `rsp_mismatch` is 1 exactly when the intermediate value is below −10. An intermediate value from −10 to −1 is clamped without the flag.
- R7: Every division truncates toward zero for any sign of operands. For example, a channel with v2 < v1 gets a negative gain, and its responses are truncated toward zero.
- R8: A division with a zero divisor yields a quotient of 0. This covers both a channel with x2 = x1 and a channel whose k is 0.
- R9: While `busy` is 1, `req_valid`, `cal_start` and `cfg_we` are ignored. No response is produced, no calibration is started, and no setup value changes.
- R10: Each accepted request gives exactly one response. `rsp_valid` is high for one cycle, and `busy` is 0 in that same cycle.
- R11: When `cal_start` and `req_valid` are both high in an idle cycle, calibration starts and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the setup values below into channel `cfg_ch` |
| cfg_ch | input | 4 | Channel addressed by a setup write |
| cfg_x1 | input | 16 | Lower ideal code, signed |
| cfg_x2 | input | 16 | Upper ideal code, signed |
| cfg_v1 | input | 16 | Voltage expected at the lower code, signed |
| cfg_v2 | input | 16 | Voltage expected at the upper code, signed |
| cfg_d1 | input | 16 | Trim deviation at the lower point, signed |
| cfg_d2 | input | 16 | Trim deviation at the upper point, signed |
| cfg_uncal | input | 1 | 1 marks the channel as uncalibrated |
| cal_start | input | 1 | Start calibration of all channels |
| req_valid | input | 1 | Conversion request |
| req_ch | input | 4 | Channel of the request |
| req_raw | input | 12 | Raw code of the request, unsigned |
| busy | output | 1 | Calibration or conversion in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Corrected reading, signed |
| rsp_mismatch | output | 1 | Intermediate value was below −10 |

## Verification
The assertions assume that every operand product stays inside signed 32 bits. They also assume that no division has a most-negative dividend paired with a divisor of −1. The stimulus uses setup values of a few thousand and raw codes up to 4095, so every product stays far inside that range. The stimulus also never writes a setup value and starts calibration in the same cycle.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int DW      = 32;
  localparam int SCALE   = 1000;
  localparam int MIS_LIM = -10;

  typedef logic signed [DW-1:0] sword_t;
  typedef logic        [DW-1:0] uword_t;

  function automatic uword_t f_mag(input sword_t x);
    return (x < 0) ? uword_t'(-x) : uword_t'(x);
  endfunction

  function automatic sword_t f_err_num(input sword_t d1, input sword_t d2);
    return SCALE * (d2 - d1);
  endfunction

  function automatic sword_t f_gain_num(input sword_t v1, input sword_t v2);
    return (v2 - v1) * SCALE;
  endfunction

  // kq is k minus SCALE, i.e. the raw quotient of the error division
  function automatic sword_t f_offset(input sword_t d1, input sword_t x1, input sword_t kq);
    return d1 * SCALE - kq * x1;
  endfunction

  function automatic sword_t f_conv_num(input sword_t raw, input sword_t off);
    return raw * SCALE - off;
  endfunction

  function automatic sword_t f_clamp(input sword_t t);
    return (t < 0) ? '0 : t;
  endfunction
endpackage

// File: rtl/adc_cal_div.sv
module adc_cal_div
  import adc_cal_pkg::*;
#(
  parameter int W = DW
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  sword_t dividend,
  input  sword_t divisor,
  output logic   running,
  output logic   done,
  output sword_t quotient
);
  localparam int CNT_W = $clog2(W);

  logic [CNT_W-1:0] cnt;
  uword_t           rem, quo, amag, bmag;
  logic             neg, zero;
  logic [W:0]       trial;

  assign trial    = {rem, quo[W-1]};
  assign quotient = zero ? '0 : (neg ? -sword_t'(quo) : sword_t'(quo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rem <= '0; quo <= '0; amag <= '0; bmag <= '0;
      neg <= 1'b0; zero <= 1'b0; running <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        amag    <= f_mag(dividend);
        bmag    <= f_mag(divisor);
        quo     <= f_mag(dividend);
        rem     <= '0;
        neg     <= dividend[W-1] ^ divisor[W-1];
        zero    <= (divisor == '0);
        cnt     <= '0;
        running <= 1'b1;
      end else if (running) begin
        if (trial >= {1'b0, bmag}) begin
          rem <= uword_t'(trial - {1'b0, bmag});
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(W-1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  // R7
  quot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zero) |-> ((64'(quo) * 64'(bmag) <= 64'(amag)) &&
                         (64'(amag) - 64'(quo) * 64'(bmag) < 64'(bmag))));
endmodule

// File: rtl/adc_cal_corrector.sv
module adc_cal_corrector
  import adc_cal_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int CODE_W = 12,
  parameter int CFG_W  = 16,
  localparam int CHW   = $clog2(NCH > 1 ? NCH : 2)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CHW-1:0]          cfg_ch,
  input  logic signed [CFG_W-1:0] cfg_x1,
  input  logic signed [CFG_W-1:0] cfg_x2,
  input  logic signed [CFG_W-1:0] cfg_v1,
  input  logic signed [CFG_W-1:0] cfg_v2,
  input  logic signed [CFG_W-1:0] cfg_d1,
  input  logic signed [CFG_W-1:0] cfg_d2,
  input  logic                    cfg_uncal,
  input  logic                    cal_start,
  input  logic                    req_valid,
  input  logic [CHW-1:0]          req_ch,
  input  logic [CODE_W-1:0]       req_raw,
  output logic                    busy,
  output logic                    rsp_valid,
  output sword_t                  rsp_data,
  output logic                    rsp_mismatch
);
  typedef enum logic [2:0] {ST_IDLE, ST_CK, ST_CG, ST_VK, ST_VG} st_t;

  st_t            st;
  logic [CHW-1:0] ch_q, cal_idx;
  sword_t         x1_t [NCH], x2_t [NCH], v1_t [NCH], v2_t [NCH], d1_t [NCH], d2_t [NCH];
  sword_t         k_t [NCH], g_t [NCH], off_t [NCH];
  logic           unc_t [NCH];
  sword_t         t_clamp, raw_s;
  logic           mis_q;

  logic   div_go, div_run, div_done;
  sword_t div_a, div_b, div_q;

  assign raw_s   = sword_t'(DW'(req_raw));
  assign busy    = (st != ST_IDLE);
  assign cal_idx = (st == ST_IDLE) ? '0 : ((st == ST_CG) ? ch_q + 1'b1 : ch_q);

  adc_cal_div #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go), .dividend(div_a), .divisor(div_b),
    .running(div_run), .done(div_done), .quotient(div_q)
  );

  always_comb begin
    div_go = 1'b0;
    div_a  = '0;
    div_b  = '0;
    case (st)
      ST_IDLE: begin
        if (cal_start) begin
          div_go = 1'b1;
          div_a  = f_err_num(d1_t[cal_idx], d2_t[cal_idx]);
          div_b  = x2_t[cal_idx] - x1_t[cal_idx];
        end else if (req_valid) begin
          div_go = 1'b1;
          if (unc_t[req_ch]) begin
            div_a = raw_s * g_t[req_ch];
            div_b = SCALE;
          end else begin
            div_a = f_conv_num(raw_s, off_t[req_ch]);
            div_b = k_t[req_ch];
          end
        end
      end
      ST_CK: if (div_done) begin
        div_go = 1'b1;
        div_a  = f_gain_num(v1_t[cal_idx], v2_t[cal_idx]);
        div_b  = x2_t[cal_idx] - x1_t[cal_idx];
      end
      ST_CG: if (div_done && ch_q != CHW'(NCH-1)) begin
        div_go = 1'b1;
        div_a  = f_err_num(d1_t[cal_idx], d2_t[cal_idx]);
        div_b  = x2_t[cal_idx] - x1_t[cal_idx];
      end
      ST_VK: if (div_done) begin
        div_go = 1'b1;
        div_a  = f_clamp(div_q) * g_t[ch_q];
        div_b  = SCALE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ch_q <= '0; t_clamp <= '0; mis_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0; rsp_mismatch <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        x1_t[i] <= '0; x2_t[i] <= '0; v1_t[i] <= '0; v2_t[i] <= '0;
        d1_t[i] <= '0; d2_t[i] <= '0; unc_t[i] <= 1'b0;
        k_t[i] <= '0; g_t[i] <= '0; off_t[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (cfg_we && st == ST_IDLE) begin
        x1_t[cfg_ch] <= sword_t'(cfg_x1); x2_t[cfg_ch] <= sword_t'(cfg_x2);
        v1_t[cfg_ch] <= sword_t'(cfg_v1); v2_t[cfg_ch] <= sword_t'(cfg_v2);
        d1_t[cfg_ch] <= sword_t'(cfg_d1); d2_t[cfg_ch] <= sword_t'(cfg_d2);
        unc_t[cfg_ch] <= cfg_uncal;
      end
      case (st)
        ST_IDLE: begin
          if (cal_start) begin
            ch_q <= '0;
            st   <= ST_CK;
          end else if (req_valid) begin
            ch_q <= req_ch;
            if (unc_t[req_ch]) begin
              t_clamp <= raw_s;
              mis_q   <= 1'b0;
              st      <= ST_VG;
            end else begin
              st <= ST_VK;
            end
          end
        end
        ST_CK: if (div_done) begin
          k_t[ch_q]   <= SCALE + div_q;
          off_t[ch_q] <= f_offset(d1_t[ch_q], x1_t[ch_q], div_q);
          st          <= ST_CG;
        end
        ST_CG: if (div_done) begin
          g_t[ch_q] <= div_q;
          if (ch_q == CHW'(NCH-1)) st <= ST_IDLE;
          else begin
            ch_q <= ch_q + 1'b1;
            st   <= ST_CK;
          end
        end
        ST_VK: if (div_done) begin
          t_clamp <= f_clamp(div_q);
          mis_q   <= (div_q < MIS_LIM);
          st      <= ST_VG;
        end
        ST_VG: if (div_done) begin
          rsp_valid    <= 1'b1;
          rsp_data     <= div_q;
          rsp_mismatch <= mis_q;
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  busy_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_run |-> busy);
  // R5
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VG) |-> (t_clamp >= 0));
  // R6
  mismatch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mismatch) |-> (rsp_data == 0));
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/adc_cal_corrector_bench.sv
module adc_cal_corrector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_uncal = 0, cal_start = 0, req_valid = 0;
  logic [3:0] cfg_ch = 0, req_ch = 0;
  logic signed [15:0] cfg_x1 = 0, cfg_x2 = 0, cfg_v1 = 0, cfg_v2 = 0, cfg_d1 = 0, cfg_d2 = 0;
  logic [11:0] req_raw = 0;
  logic busy, rsp_valid, rsp_mismatch;
  logic signed [31:0] rsp_data;

  int checks = 0, fails = 0, rsp_cnt = 0;
  int mx1 [NCH], mx2 [NCH], mv1 [NCH], mv2 [NCH], md1 [NCH], md2 [NCH];
  bit munc [NCH];
  int mk [NCH], mg [NCH], moff [NCH];
  int exp_data [$];
  bit exp_mis [$];
  string exp_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cal_corrector u_adc_cal_corrector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_x1(cfg_x1), .cfg_x2(cfg_x2), .cfg_v1(cfg_v1), .cfg_v2(cfg_v2),
    .cfg_d1(cfg_d1), .cfg_d2(cfg_d2), .cfg_uncal(cfg_uncal),
    .cal_start(cal_start), .req_valid(req_valid), .req_ch(req_ch), .req_raw(req_raw),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_mismatch(rsp_mismatch)
  );

  function automatic int sdiv(int a, int b);
    return (b == 0) ? 0 : a / b;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // model of calibration
  task automatic model_cal();
    for (int c = 0; c < NCH; c++) begin
      int q;
      q = sdiv(1000 * (md2[c] - md1[c]), mx2[c] - mx1[c]);
      mk[c]   = 1000 + q;
      mg[c]   = sdiv((mv2[c] - mv1[c]) * 1000, mx2[c] - mx1[c]);
      moff[c] = md1[c] * 1000 - (mk[c] - 1000) * mx1[c];
    end
  endtask

  // response monitor, compared every clock
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_cnt++;
      if (exp_data.size() == 0) check(1'b0, "R10 unexpected response", rsp_data, 0);
      else begin
        int ed; bit em; string tg;
        ed = exp_data.pop_front(); em = exp_mis.pop_front(); tg = exp_tag.pop_front();
        check(rsp_data == ed, {tg, " data"}, rsp_data, ed);
        check(rsp_mismatch == em, {tg, " mismatch"}, rsp_mismatch, em);
        check(!busy, "R10 busy with response", busy, 0);
      end
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_cfg(int c, int x1, int x2, int v1, int v2, int d1, int d2, bit u);
    @(negedge clk);
    wait_idle();
    cfg_we = 1; cfg_ch = 4'(c); cfg_x1 = 16'(x1); cfg_x2 = 16'(x2);
    cfg_v1 = 16'(v1); cfg_v2 = 16'(v2); cfg_d1 = 16'(d1); cfg_d2 = 16'(d2); cfg_uncal = u;
    mx1[c] = x1; mx2[c] = x2; mv1[c] = v1; mv2[c] = v2; md1[c] = d1; md2[c] = d2; munc[c] = u;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic calibrate();
    @(negedge clk);
    wait_idle();
    cal_start = 1;
    model_cal();
    @(negedge clk);
    cal_start = 0;
    check(busy == 1'b1, "R2 busy after cal_start", busy, 1);
    wait_idle();
  endtask

  task automatic convert(int c, int raw, string tag);
    int t, r; bit m;
    @(negedge clk);
    wait_idle();
    req_valid = 1; req_ch = 4'(c); req_raw = 12'(raw);
    if (munc[c]) t = raw; else t = sdiv(raw * 1000 - moff[c], mk[c]);
    m = (t < -10);
    if (t < 0) t = 0;
    r = sdiv(t * mg[c], 1000);
    exp_data.push_back(r); exp_mis.push_back(m); exp_tag.push_back(tag);
    @(negedge clk);
    req_valid = 0;
    while (exp_data.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int c0;
    for (int c = 0; c < NCH; c++) begin
      mx1[c] = 0; mx2[c] = 0; mv1[c] = 0; mv2[c] = 0; md1[c] = 0; md2[c] = 0; munc[c] = 0;
    end
    model_cal();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy in reset", busy, 0);
    check(rsp_valid == 0, "R1 rsp_valid in reset", rsp_valid, 0);
    check(rsp_data == 0, "R1 rsp_data in reset", rsp_data, 0);
    check(rsp_mismatch == 0, "R1 rsp_mismatch in reset", rsp_mismatch, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 coefficients zero before any calibration: calibrated ch0 divides by k=0
    convert(0, 2000, "R1 uncalibrated state");

    set_cfg(0, 2064, 3112, 630, 950, 5, -3, 0);
    set_cfg(1, 0, 0, 0, 0, 0, 0, 1);
    set_cfg(2, 0, 4095, 0, 1800, 0, 0, 1);
    set_cfg(3, 2064, 3112, 950, 630, 2, 4, 0);
    set_cfg(4, 2064, 3112, 630, 950, 5, 5, 0);
    set_cfg(5, 2064, 3112, 630, 950, 50, 50, 0);
    set_cfg(7, 2064, 3112, 630, 950, 0, -1048, 0);
    set_cfg(15, 2064, 3112, 3645, 5225, -12, 9, 0);

    // R9 setup write during calibration is dropped
    @(negedge clk);
    wait_idle();
    cal_start = 1;
    model_cal();
    @(negedge clk);
    cal_start = 0;
    check(busy == 1'b1, "R2 busy after cal_start", busy, 1);
    cfg_we = 1; cfg_ch = 4'd6; cfg_x1 = 0; cfg_x2 = 4095; cfg_v1 = 0; cfg_v2 = 4095;
    cfg_d1 = 0; cfg_d2 = 0; cfg_uncal = 1;
    @(negedge clk);
    cfg_we = 0;
    check(busy == 1'b1, "R2 busy during calibration", busy, 1);
    wait_idle();

    // R3 calibrated conversions, several codes
    convert(0, 2064, "R3 ch0 low point");
    convert(0, 3112, "R3 ch0 high point");
    convert(0, 4095, "R3 ch0 full scale");
    convert(0, 1234, "R3 ch0 mid code");
    convert(15, 2500, "R3 ch15 last channel");
    convert(15, 4000, "R3 ch15 high code");
    // R4 uncalibrated bypass
    convert(1, 3000, "R4 ch1 zero gain");
    convert(2, 4095, "R4 ch2 bypass full");
    convert(2, 17, "R4 ch2 bypass small");
    // R7 negative gain, truncation toward zero
    convert(3, 2777, "R7 ch3 negative gain");
    convert(3, 1, "R7 ch3 negative gain small");
    // R5 R6 clamp windows
    convert(4, 0, "R6 ch4 clamp without flag");
    convert(4, 5, "R6 ch4 at zero");
    convert(5, 0, "R6 ch5 mismatch flag");
    convert(5, 30, "R5 ch5 clamp negative");
    // R8 zero divisor paths
    convert(7, 4095, "R8 ch7 k zero");
    convert(9, 3000, "R8 ch9 equal codes");
    // R9 ch6 must keep zero setup
    convert(6, 2000, "R9 ch6 write while busy");

    // R9 request and cal_start while busy are ignored
    @(negedge clk);
    wait_idle();
    req_valid = 1; req_ch = 0; req_raw = 12'd2100;
    exp_data.push_back(sdiv(((2100 * 1000 - moff[0]) / mk[0] < 0 ? 0 : (2100 * 1000 - moff[0]) / mk[0]) * mg[0], 1000));
    exp_mis.push_back(1'b0); exp_tag.push_back("R9 first request");
    @(negedge clk);
    req_raw = 12'd100; cal_start = 1;
    @(negedge clk);
    req_valid = 0; cal_start = 0;
    c0 = rsp_cnt;
    wait_idle();
    repeat (4) @(negedge clk);
    check(busy == 0, "R9 cal_start while busy ignored", busy, 0);
    check(rsp_cnt == c0 + 1, "R9 one response only", rsp_cnt - c0, 1);

    // R11 cal_start wins over a request in the same cycle
    set_cfg(0, 2064, 3112, 630, 950, -7, 11, 0);
    @(negedge clk);
    wait_idle();
    c0 = rsp_cnt;
    cal_start = 1; req_valid = 1; req_ch = 2; req_raw = 12'd500;
    model_cal();
    @(negedge clk);
    cal_start = 0; req_valid = 0;
    check(busy == 1'b1, "R11 calibration started", busy, 1);
    wait_idle();
    repeat (4) @(negedge clk);
    check(rsp_cnt == c0, "R11 request dropped", rsp_cnt - c0, 0);
    convert(0, 2064, "R2 recalibrated ch0");
    convert(0, 3500, "R2 recalibrated ch0 high");

    repeat (3) @(negedge clk);
    check(exp_data.size() == 0, "R10 pending responses", exp_data.size(), 0);
    summary();
  end
endmodule